// File: doc/BRIEF.md
# Link Transmit Symbol Scheduler

This block sits on the transmit side of a serial link endpoint, in front of the 8b10b encoder. Every clock it picks exactly one character for the encoder to send. There are four kinds of traffic. The first is a global reset request, which may be held for a long time. The second is an 8-bit bus of trigger strobes. The third is an 11-byte register message that travels inside a start marker and an end marker. When none of these has anything to send, the block fills the cycle with the idle comma.

Triggers must keep a fixed latency, so they are never held back by message bytes. When a trigger takes a slot, the message simply pauses and continues with its next character afterwards. On the host side the block allows only one request at a time. Once a message is accepted, `req_ready` stays low until the returning response's end marker is reported, or until a programmable wait after the end marker has run out. Because of this the link needs no backpressure.

The emitted character is registered. A decision made in cycle n appears on `tx_char`/`tx_is_k` in cycle n+1.

Top module: `lts_tx_sched`

## Requirements
- R1: After reset `tx_char`=0xBC with `tx_is_k`=1 (idle comma) and `req_ready`=1. The idle comma is also sent in every cycle with no reset, trigger or frame character to send.
- R2: While `gr_req` is high in cycle n, cycle n+1 carries 0x3C with `tx_is_k`=1. This overrides triggers and frame characters.
- R3: Trigger bit i maps to a control character: bit0→0x5C, bit1→0x7C, bit2→0x9C, bit3→0xDC, bit4→0xFC, bit5→0xF7, bit6→0xFB, bit7→0xFD. Trigger bit i is the only pending trigger when it is requested in cycle n with `gr_req` low. In that case its character appears in cycle n+1.
- R4: Trigger bits that are requested together, or while `gr_req` is high, are kept pending. They are sent one per free cycle, lowest bit first. Requests for the same bit that overlap collapse into one character.
- R5: An accepted message is sent in three parts. First comes 0x1C (k=1). Then the 11 bytes of `req_msg` follow with k=0, byte j taken from bits [8j+7:8j], starting with j=0. Last comes 0xFE (k=1).
- R6: A trigger or reset character that lands inside a frame delays the frame. The frame then resumes with its next character, and no character is lost or repeated.
- R7: A message is accepted when `req_valid` is high while `req_ready` is high. `req_ready` then falls in the next cycle. `req_valid` while `req_ready` is low is ignored.
- R8: `rsp_eof` high in a cycle after the frame's end marker has been emitted raises `req_ready` in the next cycle. `rsp_eof` while the frame is still being sent is ignored.
- R9: Without a response, `req_ready` rises exactly `timeout_limit` cycles after the cycle in which 0xFE appears on `tx_char`. A limit of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gr_req | input | 1 | Global reset request, level |
| trig_req | input | 8 | Trigger strobes, one bit per trigger |
| req_valid | input | 1 | Host offers a request message |
| req_msg | input | 88 | Request message, byte j at bits [8j+7:8j] |
| req_ready | output | 1 | No request outstanding; a message can be accepted |
| rsp_eof | input | 1 | End marker of the response was received |
| timeout_limit | input | 16 | Wait cycles after the end marker before the request is dropped |
| tx_char | output | 8 | Character to the 8b10b encoder |
| tx_is_k | output | 1 | Character is a control character |

## Verification
Trigger and frame traffic fall in the same cycle most often. The bench provokes this by sending sparse random trigger bursts, sometimes several bits at once, while messages are in flight. It also holds reset requests long enough to queue triggers behind them. A cycle-level reference model in the bench works out from the priority rules which character is due in each cycle. Every output character and `req_ready` is compared with that model. This checks that frames stall and resume without gaps and that triggers keep their one-cycle latency. A second overlap occurs when a response end marker arrives in the same cycle as the timeout expiry or during frame transmission. The model judges both by the release rules.

// File: rtl/lts_pkg.sv
package lts_pkg;

    localparam int TRIG_W = 8;

    localparam logic [7:0] K_IDLE = 8'hBC;
    localparam logic [7:0] K_GRST = 8'h3C;
    localparam logic [7:0] K_SOF  = 8'h1C;
    localparam logic [7:0] K_EOF  = 8'hFE;

    typedef struct packed {
        logic [7:0] data;
        logic       is_k;
    } tx_sym_t;

    typedef enum logic [2:0] {
        FS_FREE,
        FS_SOF,
        FS_DATA,
        FS_EOF,
        FS_WAIT
    } frame_st_e;

    function automatic logic [7:0] trig_code(input logic [2:0] bit_idx);
        logic [7:0] code;
        unique case (bit_idx)
            3'd0: code = 8'h5C;
            3'd1: code = 8'h7C;
            3'd2: code = 8'h9C;
            3'd3: code = 8'hDC;
            3'd4: code = 8'hFC;
            3'd5: code = 8'hF7;
            3'd6: code = 8'hFB;
            default: code = 8'hFD;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/lts_trig_queue.sv
module lts_trig_queue
    import lts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TRIG_W-1:0] trig_req,
    input  logic              hold,
    output logic              out_valid,
    output tx_sym_t           out_sym
);

    logic [TRIG_W-1:0] pend_q, pend_d, merged, pick;
    logic [2:0]        sel_idx;

    always_comb begin
        merged  = pend_q | trig_req;
        sel_idx = '0;
        for (int i = TRIG_W - 1; i >= 0; i--) begin
            if (merged[i]) sel_idx = 3'(i);
        end
        pick      = TRIG_W'(1) << sel_idx;
        out_valid = |merged;
        out_sym   = '{data: trig_code(sel_idx), is_k: 1'b1};
        pend_d    = (hold || !out_valid) ? merged : (merged & ~pick);
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    // R4: with no new requests and no hold, exactly one pending bit drains
    assert_one_drain_R4: assert property (@(posedge clk) disable iff (rst)
        (!hold && trig_req == '0 && pend_q != '0)
        |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

endmodule

// File: rtl/lts_frame_seq.sv
module lts_frame_seq
    import lts_pkg::*;
#(
    parameter int MSG_BYTES = 11,
    parameter int TO_W      = 16,
    localparam int MSG_W    = 8 * MSG_BYTES,
    localparam int IDX_W    = $clog2(MSG_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [MSG_W-1:0] req_msg,
    output logic             req_ready,
    input  logic             adv,
    input  logic             rsp_eof,
    input  logic [TO_W-1:0]  timeout_limit,
    output logic             out_valid,
    output tx_sym_t          out_sym
);

    frame_st_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [TO_W-1:0]  cnt_q, cnt_d, lim_eff;
    logic [MSG_W-1:0] msg_q, msg_d;
    logic             last_byte;

    assign req_ready = (state_q == FS_FREE);
    assign lim_eff   = (timeout_limit == '0) ? TO_W'(1) : timeout_limit;
    assign last_byte = (idx_q == IDX_W'(MSG_BYTES - 1));

    always_comb begin
        out_valid = (state_q == FS_SOF) || (state_q == FS_DATA) || (state_q == FS_EOF);
        unique case (state_q)
            FS_SOF:  out_sym = '{data: K_SOF, is_k: 1'b1};
            FS_DATA: out_sym = '{data: msg_q[int'(idx_q) * 8 +: 8], is_k: 1'b0};
            FS_EOF:  out_sym = '{data: K_EOF, is_k: 1'b1};
            default: out_sym = '{data: K_IDLE, is_k: 1'b1};
        endcase
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        msg_d   = msg_q;
        unique case (state_q)
            FS_FREE: if (req_valid) begin
                msg_d   = req_msg;
                state_d = FS_SOF;
            end
            FS_SOF: if (adv) begin
                state_d = FS_DATA;
                idx_d   = '0;
            end
            FS_DATA: if (adv) begin
                if (last_byte) state_d = FS_EOF;
                else           idx_d   = idx_q + 1'b1;
            end
            FS_EOF: if (adv) begin
                state_d = FS_WAIT;
                cnt_d   = '0;
            end
            FS_WAIT: begin
                if (rsp_eof || cnt_q >= lim_eff - 1'b1) state_d = FS_FREE;
                else                                    cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = FS_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_FREE;
            idx_q   <= '0;
            cnt_q   <= '0;
            msg_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
            msg_q   <= msg_d;
        end
    end

    // R6: a frame character that loses arbitration is offered again unchanged
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !adv) |=> ($stable(state_q) && $stable(idx_q)));

    // R7: an offer while busy leaves the latched message untouched
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && req_valid) |=> $stable(msg_q));

    // R8: a response while waiting frees the request slot next cycle
    assert_rsp_release_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_WAIT && rsp_eof) |=> req_ready);

endmodule

// File: rtl/lts_tx_sched.sv
module lts_tx_sched
    import lts_pkg::*;
#(
    parameter int MSG_BYTES = 11,
    parameter int TO_W      = 16,
    localparam int MSG_W    = 8 * MSG_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gr_req,
    input  logic [TRIG_W-1:0] trig_req,
    input  logic              req_valid,
    input  logic [MSG_W-1:0]  req_msg,
    output logic              req_ready,
    input  logic              rsp_eof,
    input  logic [TO_W-1:0]   timeout_limit,
    output logic [7:0]        tx_char,
    output logic              tx_is_k
);

    logic    trig_valid, frame_valid, frame_adv;
    tx_sym_t trig_sym, frame_sym, pick_sym;

    lts_trig_queue u_trig (
        .clk       (clk),
        .rst       (rst),
        .trig_req  (trig_req),
        .hold      (gr_req),
        .out_valid (trig_valid),
        .out_sym   (trig_sym)
    );

    assign frame_adv = !gr_req && !trig_valid;

    lts_frame_seq #(
        .MSG_BYTES (MSG_BYTES),
        .TO_W      (TO_W)
    ) u_frame (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_msg       (req_msg),
        .req_ready     (req_ready),
        .adv           (frame_adv),
        .rsp_eof       (rsp_eof),
        .timeout_limit (timeout_limit),
        .out_valid     (frame_valid),
        .out_sym       (frame_sym)
    );

    always_comb begin
        if (gr_req)           pick_sym = '{data: K_GRST, is_k: 1'b1};
        else if (trig_valid)  pick_sym = trig_sym;
        else if (frame_valid) pick_sym = frame_sym;
        else                  pick_sym = '{data: K_IDLE, is_k: 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_char <= K_IDLE;
            tx_is_k <= 1'b1;
        end else begin
            tx_char <= pick_sym.data;
            tx_is_k <= pick_sym.is_k;
        end
    end

    // R2: a reset request owns the next character slot
    assert_gr_wins_R2: assert property (@(posedge clk) disable iff (rst)
        gr_req |=> (tx_char == K_GRST && tx_is_k));

    // R3: the lowest trigger bit is never delayed when no reset is requested
    assert_trig0_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (!gr_req && trig_req[0]) |=> (tx_char == 8'h5C && tx_is_k));

endmodule

// File: tb/lts_tx_sched_bench.sv
module lts_tx_sched_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gr_req = 1'b0;
    logic [7:0]  trig_req = '0;
    logic        req_valid = 1'b0;
    logic [87:0] req_msg = '0;
    logic        req_ready;
    logic        rsp_eof = 1'b0;
    logic [15:0] timeout_limit = 16'd4;
    logic [7:0]  tx_char;
    logic        tx_is_k;

    int n_cmp = 0;
    int n_bad = 0;
    bit chk_en = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lts_tx_sched u_lts_tx_sched (
        .clk(clk), .rst(rst), .gr_req(gr_req), .trig_req(trig_req),
        .req_valid(req_valid), .req_msg(req_msg), .req_ready(req_ready),
        .rsp_eof(rsp_eof), .timeout_limit(timeout_limit),
        .tx_char(tx_char), .tx_is_k(tx_is_k)
    );

    function automatic logic [7:0] exp_trig(input int b);
        case (b)
            0: return 8'h5C;  1: return 8'h7C;  2: return 8'h9C;  3: return 8'hDC;
            4: return 8'hFC;  5: return 8'hF7;  6: return 8'hFB;  default: return 8'hFD;
        endcase
    endfunction

    // cycle-level expectation built from the requirement text
    logic [7:0]  m_pend = '0;
    int          m_st = 0, m_idx = 0, m_cnt = 0;
    logic [87:0] m_msg = '0;
    logic [7:0]  e_char = 8'hBC;
    logic        e_k = 1'b1;
    string       e_tag = "R1";
    string       r_tag = "R1";
    bit          m_stalled = 1'b0;

    always @(posedge clk) begin
        logic [7:0] all;
        int lim, low;
        bit adv;
        if (rst) begin
            m_pend = '0; m_st = 0; m_idx = 0; m_cnt = 0; m_stalled = 0;
            e_char = 8'hBC; e_k = 1'b1; e_tag = "R1"; r_tag = "R1";
        end else begin
            all = m_pend | trig_req;
            adv = 1'b0;
            low = 0;
            for (int b = 7; b >= 0; b--) if (all[b]) low = b;
            if (gr_req) begin
                e_char = 8'h3C; e_k = 1'b1; e_tag = "R2"; m_pend = all;
                if (m_st >= 1 && m_st <= 3) m_stalled = 1;
            end else if (all != 0) begin
                e_char = exp_trig(low); e_k = 1'b1;
                e_tag = ($countones(all) > 1 || m_pend != 0) ? "R4" : "R3";
                m_pend = all & ~(8'd1 << low);
                if (m_st >= 1 && m_st <= 3) m_stalled = 1;
            end else if (m_st >= 1 && m_st <= 3) begin
                adv = 1'b1;
                e_tag = m_stalled ? "R6" : "R5";
                m_stalled = 0;
                if (m_st == 1)      begin e_char = 8'h1C; e_k = 1'b1; end
                else if (m_st == 2) begin e_char = m_msg[m_idx*8 +: 8]; e_k = 1'b0; end
                else                begin e_char = 8'hFE; e_k = 1'b1; end
            end else begin
                e_char = 8'hBC; e_k = 1'b1; e_tag = "R1";
            end
            lim = (timeout_limit == 0) ? 1 : int'(timeout_limit);
            case (m_st)
                0: if (req_valid) begin m_msg = req_msg; m_st = 1; r_tag = "R7"; end
                1: if (adv) begin m_st = 2; m_idx = 0; end
                2: if (adv) begin if (m_idx == NB - 1) m_st = 3; else m_idx++; end
                3: if (adv) begin m_st = 4; m_cnt = 0; end
                default: begin
                    if (rsp_eof)               begin m_st = 0; r_tag = "R8"; end
                    else if (m_cnt + 1 >= lim) begin m_st = 0; r_tag = "R9"; end
                    else m_cnt++;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            n_cmp++;
            if (tx_char !== e_char || tx_is_k !== e_k) begin
                n_bad++;
                $display("FAIL %s: tx char/k actual %h/%b expected %h/%b at %0t",
                         e_tag, tx_char, tx_is_k, e_char, e_k, $time);
            end
            n_cmp++;
            if (req_ready !== (m_st == 0)) begin
                n_bad++;
                $display("FAIL %s: req_ready actual %b expected %b at %0t",
                         r_tag, req_ready, (m_st == 0), $time);
            end
        end
    end

    task automatic drive(input bit g, input logic [7:0] t, input bit rv, input bit re);
        @(negedge clk);
        gr_req = g; trig_req = t; req_valid = rv; rsp_eof = re;
        req_msg = {$urandom, $urandom, $urandom};
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) drive(0, 8'h00, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (tx_char !== 8'hBC || tx_is_k !== 1'b1 || req_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R1: reset char/k/ready actual %h/%b/%b expected bc/1/1",
                     tx_char, tx_is_k, req_ready);
        end
        chk_en = 1'b1;

        // R3: each trigger alone
        for (int b = 0; b < 8; b++) begin drive(0, 8'd1 << b, 0, 0); idle_n(2); end
        // R4: all triggers together, then a repeat overlapping the drain
        drive(0, 8'hFF, 0, 0); drive(0, 8'h81, 0, 0); idle_n(10);
        // R2 + R4: long reset request with triggers queued behind it
        drive(1, 8'h24, 0, 0);
        for (int i = 0; i < 30; i++) drive(1, (i % 7 == 0) ? 8'h11 : 8'h00, 0, 0);
        idle_n(8);
        // R5 + R7 + R9: clean frame, offers while busy, timeout of 3
        timeout_limit = 16'd3;
        drive(0, 8'h00, 1, 0);
        for (int i = 0; i < 20; i++) drive(0, 8'h00, 1, 0);
        drive(0, 8'h00, 0, 0); idle_n(6);
        // R6 + R8: triggers and reset inside a frame, rsp_eof during send ignored
        timeout_limit = 16'd40;
        drive(0, 8'h00, 1, 0); idle_n(3);
        drive(0, 8'h06, 0, 1); drive(1, 8'h00, 0, 1); drive(0, 8'h80, 0, 0);
        idle_n(18);
        drive(0, 8'h00, 0, 1); idle_n(4);
        // R9: limit of zero behaves as one
        timeout_limit = 16'd0;
        drive(0, 8'h00, 1, 0); idle_n(25);

        // mixed random traffic
        for (int i = 0; i < 6000; i++) begin
            if (i % 500 == 0) timeout_limit = 16'($urandom_range(0, 30));
            drive(($urandom_range(0, 99) < 3),
                  ($urandom_range(0, 99) < 12) ? 8'($urandom) & 8'($urandom) : 8'h00,
                  ($urandom_range(0, 99) < 30),
                  ($urandom_range(0, 99) < 4));
        end
        idle_n(60);
        chk_en = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1: watchdog expired actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule